// File: doc/BRIEF.md
# Capture/Compare Timer Channel

A single 32-bit timer channel for a system-on-chip peripheral set. The count clock is chosen from three sources: every system clock, one system clock in sixteen, or rising edges of an external count pin. That pin is first passed through a two-flop synchronizer and an edge detector. An 8-bit prescaler follows the source choice, and a prescale value N lets one count through for every N+1 source strobes.

The counter either runs freely and wraps at its full range, or returns to zero after it reaches a reference value. A capture input, synchronized the same way, latches the counter on a selectable edge. A reference match drives an output pin by pulsing or toggling it. Capture and compare events set sticky flags. Each event can be masked, and an unmasked event goes either to an interrupt line or to a DMA request that is held until acknowledged.

Software reaches the channel through a small register port. Writes take one clock. Reads are combinational on the address.

| Addr | Register | Contents |
|------|----------|----------|
| 3'd0 | CTRL | [1:0] source (00 stopped, 01 every clock, 10 every 16th clock, 11 count pin); [2] restart mode; [4:3] capture edge (00 off, 01 rising, 10 falling, 11 both); [6:5] pin action (00 none, 01 pulse, 10 toggle, 11 none); [7] capture enable; [8] capture to DMA; [9] compare enable; [10] compare to DMA; [23:16] prescale |
| 3'd1 | REF | reference value |
| 3'd2 | CAP | captured value (read only) |
| 3'd3 | CNT | counter; a write loads it |
| 3'd4 | FLAG | [0] capture flag, [1] compare flag; write 1 to clear |

Top module: `capcmp_timer`

## Requirements
- R1: After reset, CTRL, REF, CAP, CNT and FLAG read 0, and irq_o, dma_req_o and cmp_pin_o are low.
- R2: CTRL[1:0] selects the count strobe: 00 holds the counter, 01 strobes every clock, 10 strobes every 16th clock, and 11 strobes on each rising edge of cnt_pin_i after a two-flop synchronizer.
- R3: With prescale N in CTRL[23:16], the counter advances once per N+1 strobes of the selected source.
- R4: In free-run mode (CTRL[2]=0), the counter steps from 32'hFFFFFFFF to 0.
- R5: In restart mode (CTRL[2]=1), a count strobe that finds the counter equal to REF sets it to 0, so the counter cycles 0..REF.
- R6: The edge that CTRL[4:3] selects on cap_pin_i copies CNT into CAP and sets FLAG[0]. Non-selected edges, and any edge when the field is 00, change neither CAP nor FLAG[0].
- R7: A count strobe that finds the counter equal to REF sets FLAG[1].
- R8: On each compare event, pin action 01 drives cmp_pin_o high for exactly one clock and action 10 inverts it. Actions 00 and 11 leave the pin unchanged.
- R9: FLAG bits stay set until software writes 1 to them.
- R10: irq_o is high while a set flag has its enable bit set (CTRL[7] capture, CTRL[9] compare) and its route bit clear (CTRL[8], CTRL[10]). A masked flag does not raise irq_o.
- R11: An enabled event whose route bit is set raises dma_req_o instead of irq_o. dma_req_o stays high, even after its flag is cleared, until a dma_ack_i pulse.
- R12: A write to CNT loads the written value and restarts the prescaler, so with prescale N at one strobe per clock the first step comes N+1 clocks after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_wr_i | input | 1 | register write strobe |
| reg_addr_i | input | 3 | register address |
| reg_wdata_i | input | 32 | register write data |
| reg_rdata_o | output | 32 | register read data for reg_addr_i |
| cnt_pin_i | input | 1 | external count clock pin |
| cap_pin_i | input | 1 | capture input pin |
| dma_ack_i | input | 1 | DMA acknowledge pulse |
| irq_o | output | 1 | interrupt request |
| dma_req_o | output | 1 | DMA request, held until acknowledged |
| cmp_pin_o | output | 1 | compare output pin |

## Verification
The counter properties apply only in cycles with no register write. A write may legally load any counter value or change the mode, so the stimulus stops the counter before it loads CNT or REF. The restart bound assumes the counter already sits at or below REF; the bench therefore loads 0 before it enables restart mode. The pins are asynchronous and feed two-flop synchronizers, so the bench holds each pin level for at least three clocks. It also drives dma_ack_i only as a single-clock pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PSC_W   = 8;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 32;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_REF  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAP  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd4;

  localparam int EV_CAP = 0;
  localparam int EV_CMP = 1;
  localparam int NUM_EV = 2;

  typedef enum logic [1:0] {SRC_OFF, SRC_SYS, SRC_SLOW, SRC_PIN} src_e;
  typedef enum logic [1:0] {EDGE_NONE, EDGE_RISE, EDGE_FALL, EDGE_BOTH} edge_e;
  typedef enum logic [1:0] {ACT_NONE, ACT_PULSE, ACT_TOGGLE, ACT_RSVD} act_e;

  typedef struct packed {
    logic [PSC_W-1:0] psc;
    logic [4:0]       spare;
    logic             cmp_dma;
    logic             cmp_en;
    logic             cap_dma;
    logic             cap_en;
    act_e             act;
    edge_e            cap_edge;
    logic             restart;
    src_e             src;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int SH_W = STAGES + 1;

  logic [SH_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[SH_W-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tmr_pkg::*;
#(
  parameter int PW       = PSC_W,
  parameter int SLOW_DIV = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  src_e          src_i,
  input  logic [PW-1:0] psc_i,
  input  logic          pin_rise_i,
  input  logic          psc_clr_i,
  output logic          tick_o
);
  localparam int SLOW_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [SLOW_W-1:0] SLOW_LAST = SLOW_W'(SLOW_DIV - 1);

  logic [SLOW_W-1:0] slow_q, slow_d;
  logic [PW-1:0]     pcnt_q, pcnt_d;
  logic              slow_stb, src_stb;

  assign slow_stb = (slow_q == SLOW_LAST);

  always_comb begin
    slow_d = slow_stb ? '0 : slow_q + 1'b1;
  end

  always_comb begin
    unique case (src_i)
      SRC_SYS:  src_stb = 1'b1;
      SRC_SLOW: src_stb = slow_stb;
      SRC_PIN:  src_stb = pin_rise_i;
      default:  src_stb = 1'b0;
    endcase
  end

  assign tick_o = src_stb && (pcnt_q >= psc_i);

  always_comb begin
    pcnt_d = pcnt_q;
    if (psc_clr_i)    pcnt_d = '0;
    else if (tick_o)  pcnt_d = '0;
    else if (src_stb) pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q <= '0;
      pcnt_q <= '0;
    end else begin
      slow_q <= slow_d;
      pcnt_q <= pcnt_d;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          restart_i,
  input  logic [CW-1:0] ref_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          cap_stb_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cap_o,
  output logic          match_o
);
  logic [CW-1:0] cnt_q, cnt_d, cap_q, cap_d;

  assign match_o = tick_i && (cnt_q == ref_i);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                      cnt_d = load_val_i;
    else if (match_o && restart_i)   cnt_d = '0;
    else if (tick_i)                 cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    cap_d = cap_stb_i ? cnt_q : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cap_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cap_q <= cap_d;
    end
  end

  assign cnt_o = cnt_q;
  assign cap_o = cap_q;
endmodule

// File: rtl/tmr_events.sv
module tmr_events
  import tmr_pkg::*;
#(
  parameter int NE = NUM_EV
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NE-1:0] ev_stb_i,
  input  logic [NE-1:0] ev_en_i,
  input  logic [NE-1:0] ev_dma_i,
  input  logic [NE-1:0] clr_i,
  input  logic          dma_ack_i,
  input  act_e          act_i,
  input  logic          cmp_stb_i,
  output logic [NE-1:0] flags_o,
  output logic          irq_o,
  output logic          dma_req_o,
  output logic          pin_o
);
  logic [NE-1:0] flag_q, flag_d;
  logic          dreq_q, dreq_d;
  logic          pin_q, pin_d;

  for (genvar i = 0; i < NE; i++) begin : g_flag
    always_comb begin
      flag_d[i] = ev_stb_i[i] | (flag_q[i] & ~clr_i[i]);
    end
  end

  always_comb begin
    dreq_d = (|(ev_stb_i & ev_en_i & ev_dma_i)) | (dreq_q & ~dma_ack_i);
  end

  always_comb begin
    unique case (act_i)
      ACT_PULSE:  pin_d = cmp_stb_i;
      ACT_TOGGLE: pin_d = pin_q ^ cmp_stb_i;
      default:    pin_d = pin_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      dreq_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      dreq_q <= dreq_d;
      pin_q  <= pin_d;
    end
  end

  assign flags_o   = flag_q;
  assign irq_o     = |(flag_q & ev_en_i & ~ev_dma_i);
  assign dma_req_o = dreq_q;
  assign pin_o     = pin_q;
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int SLOW_DIV = 16,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              cnt_pin_i,
  input  logic              cap_pin_i,
  input  logic              dma_ack_i,
  output logic              irq_o,
  output logic              dma_req_o,
  output logic              cmp_pin_o
);
  ctrl_t             ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  ref_q, ref_d;
  logic [CNT_W-1:0]  cnt_w, cap_w;
  logic [NUM_EV-1:0] ev_flags, ev_stb, ev_en, ev_dma, flag_clr;
  logic              cpin_rise, cpin_fall, cap_rise, cap_fall;
  logic              tick, match, cap_stb, cnt_load;

  // register writes
  always_comb begin
    ctrl_d = ctrl_q;
    ref_d  = ref_q;
    if (reg_wr_i && reg_addr_i == A_CTRL) begin
      ctrl_d       = ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
      ctrl_d.spare = '0;
    end
    if (reg_wr_i && reg_addr_i == A_REF) ref_d = reg_wdata_i[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ref_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      ref_q  <= ref_d;
    end
  end

  assign cnt_load = reg_wr_i && (reg_addr_i == A_CNT);
  assign flag_clr = (reg_wr_i && reg_addr_i == A_FLAG) ? reg_wdata_i[NUM_EV-1:0] : '0;

  // pin synchronizers
  tmr_edge_sync #(.STAGES(SYNC_N)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(cnt_pin_i),
    .rise_o(cpin_rise), .fall_o(cpin_fall)
  );

  tmr_edge_sync #(.STAGES(SYNC_N)) u_cap_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(cap_pin_i),
    .rise_o(cap_rise), .fall_o(cap_fall)
  );

  always_comb begin
    unique case (ctrl_q.cap_edge)
      EDGE_RISE: cap_stb = cap_rise;
      EDGE_FALL: cap_stb = cap_fall;
      EDGE_BOTH: cap_stb = cap_rise | cap_fall;
      default:   cap_stb = 1'b0;
    endcase
  end

  tmr_tick_gen #(.PW(PSC_W), .SLOW_DIV(SLOW_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .src_i(ctrl_q.src), .psc_i(ctrl_q.psc),
    .pin_rise_i(cpin_rise), .psc_clr_i(cnt_load), .tick_o(tick)
  );

  tmr_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .restart_i(ctrl_q.restart),
    .ref_i(ref_q), .load_i(cnt_load), .load_val_i(reg_wdata_i[CNT_W-1:0]),
    .cap_stb_i(cap_stb), .cnt_o(cnt_w), .cap_o(cap_w), .match_o(match)
  );

  always_comb begin
    ev_stb          = '0;
    ev_en           = '0;
    ev_dma          = '0;
    ev_stb[EV_CAP]  = cap_stb;
    ev_stb[EV_CMP]  = match;
    ev_en[EV_CAP]   = ctrl_q.cap_en;
    ev_en[EV_CMP]   = ctrl_q.cmp_en;
    ev_dma[EV_CAP]  = ctrl_q.cap_dma;
    ev_dma[EV_CMP]  = ctrl_q.cmp_dma;
  end

  tmr_events #(.NE(NUM_EV)) u_ev (
    .clk(clk), .rst_n(rst_n), .ev_stb_i(ev_stb), .ev_en_i(ev_en),
    .ev_dma_i(ev_dma), .clr_i(flag_clr), .dma_ack_i(dma_ack_i),
    .act_i(ctrl_q.act), .cmp_stb_i(match), .flags_o(ev_flags),
    .irq_o(irq_o), .dma_req_o(dma_req_o), .pin_o(cmp_pin_o)
  );

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CTRL:  reg_rdata_o = DATA_W'(ctrl_q);
      A_REF:   reg_rdata_o = DATA_W'(ref_q);
      A_CAP:   reg_rdata_o = DATA_W'(cap_w);
      A_CNT:   reg_rdata_o = DATA_W'(cnt_w);
      A_FLAG:  reg_rdata_o = DATA_W'(ev_flags);
      default: reg_rdata_o = '0;
    endcase
  end

  logic unused_ok;
  assign unused_ok = cpin_fall;
endmodule

// File: rtl/capcmp_timer_chk.sv
module capcmp_timer_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input src_e              src,
  input logic              restart,
  input act_e              act,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  ref_v,
  input logic [1:0]        flags,
  input logic              irq,
  input logic              dma_req,
  input logic              dma_ack,
  input logic              pin
);
  // R2: a stopped source freezes the counter
  p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_OFF && !reg_wr) |=> $stable(cnt));

  // R4: free-run wraps only to zero
  p_wrap_to_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && cnt == '1 && !reg_wr) |=> (cnt == '1 || cnt == '0));

  // R5: restart mode keeps the counter within 0..REF
  p_restart_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && cnt <= ref_v && !reg_wr) |=> (cnt <= ref_v));

  // R8: no-effect actions leave the pin alone
  p_pin_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((act == ACT_NONE || act == ACT_RSVD) && !reg_wr) |=> $stable(pin));

  // R9: flags only clear by a write of 1
  p_cap_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !(reg_wr && reg_addr == A_FLAG && reg_wdata[0])) |=> flags[0]);
  p_cmp_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && !(reg_wr && reg_addr == A_FLAG && reg_wdata[1])) |=> flags[1]);

  // R10: no flag, no interrupt
  p_quiet_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == 2'b00) |-> !irq);

  // R11: request held until acknowledged
  p_dma_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack) |=> dma_req);
endmodule

bind capcmp_timer capcmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr_i), .reg_addr(reg_addr_i),
  .reg_wdata(reg_wdata_i), .src(ctrl_q.src), .restart(ctrl_q.restart),
  .act(ctrl_q.act), .cnt(cnt_w), .ref_v(ref_q), .flags(ev_flags),
  .irq(irq_o), .dma_req(dma_req_o), .dma_ack(dma_ack_i), .pin(cmp_pin_o)
);

// File: tb/capcmp_timer_test.sv
module capcmp_timer_test;
  logic        clk, rst_n, reg_wr, cnt_pin, cap_pin, dma_ack;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq, dma_req, cmp_pin;
  int          checks, errors;
  bit          done;

  capcmp_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .cnt_pin_i(cnt_pin),
    .cap_pin_i(cap_pin), .dma_ack_i(dma_ack), .irq_o(irq),
    .dma_req_o(dma_req), .cmp_pin_o(cmp_pin)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // external count pin: rising edge every 6 clocks
  initial begin
    cnt_pin = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      cnt_pin = ~cnt_pin;
    end
  end

  // source, prescale, expected clocks per count step (R2, R3)
  localparam int VEC [6][3] = '{
    '{1, 0, 1}, '{1, 3, 4}, '{2, 0, 16}, '{2, 2, 48}, '{1, 255, 256}, '{3, 1, 12}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int src, bit rs, int edg, int act, bit ce, bit cd, bit me, bit md, int psc);
    return {8'h0, 8'(psc), 5'h0, md, me, cd, ce, 2'(act), 2'(edg), rs, 2'(src)};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic step_interval(output int n);
    logic [31:0] v0, v;
    int c;
    rd(3'd3, v0); c = 0;
    do begin @(negedge clk); rd(3'd3, v); c++; end while (v == v0 && c < 3000);
    v0 = v; c = 0;
    do begin @(negedge clk); rd(3'd3, v); c++; end while (v == v0 && c < 3000);
    n = c;
  endtask

  task automatic drive_cap(input logic lvl);
    @(negedge clk); cap_pin = lvl;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, prev;
    int n, bad, wraps;
    logic p0;
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    cap_pin = 1'b0; dma_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk(v == 0, "R1 register reset", v, 0);
    end
    chk({irq, dma_req, cmp_pin} == 3'b000, "R1 outputs reset", {irq, dma_req, cmp_pin}, 0);

    // R2/R3 table walk
    for (int i = 0; i < 6; i++) begin
      wr(3'd0, mk(VEC[i][0], 0, 0, 0, 0, 0, 0, 0, VEC[i][1]));
      step_interval(n);
      chk(n == VEC[i][2], "R2/R3 step interval", n, VEC[i][2]);
    end

    // R2 stopped source
    wr(3'd0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0));
    rd(3'd3, prev);
    repeat (20) @(negedge clk);
    rd(3'd3, v);
    chk(v == prev, "R2 stopped counter", v, prev);

    // R12 load and prescaler restart
    wr(3'd3, 32'd1234);
    rd(3'd3, v);
    chk(v == 32'd1234, "R12 counter load", v, 32'd1234);
    wr(3'd0, mk(1, 0, 0, 0, 0, 0, 0, 0, 3));
    wr(3'd3, 32'd0);
    repeat (3) @(negedge clk);
    rd(3'd3, v);
    chk(v == 0, "R12 no step before N+1 clocks", v, 0);
    @(negedge clk);
    rd(3'd3, v);
    chk(v == 1, "R12 first step after N+1 clocks", v, 1);

    // R4 free-run wrap
    wr(3'd0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(3'd1, 32'd100);
    wr(3'd3, 32'hFFFF_FFFD);
    wr(3'd4, 32'h3);
    wr(3'd0, mk(1, 0, 0, 0, 0, 0, 0, 0, 0));
    rd(3'd3, prev);
    n = 0;
    do begin @(negedge clk); v = prev; rd(3'd3, prev); n++; end while (prev >= v && n < 20);
    chk(v == 32'hFFFF_FFFF && prev == 0, "R4 wrap to zero", prev, 0);

    // R5/R7 restart mode, compare masked
    wr(3'd0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(3'd1, 32'd5);
    wr(3'd3, 32'd0);
    wr(3'd4, 32'h3);
    wr(3'd0, mk(1, 1, 0, 0, 0, 0, 0, 0, 0));
    rd(3'd3, prev);
    bad = 0; wraps = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); rd(3'd3, v);
      if (prev == 5) begin if (v != 0) bad++; else wraps++; end
      else if (v != prev + 1) bad++;
      prev = v;
    end
    chk(bad == 0 && wraps >= 4, "R5 restart sequence", bad, 0);
    rd(3'd4, v);
    chk(v[1] == 1'b1, "R7 compare flag", v, 2);
    chk(irq == 1'b0, "R10 masked compare no irq", irq, 0);

    // R8 toggle action
    wr(3'd0, mk(1, 1, 0, 2, 0, 0, 0, 0, 0));
    p0 = cmp_pin; n = 0;
    do begin @(negedge clk); n++; end while (cmp_pin == p0 && n < 50);
    p0 = cmp_pin; n = 0;
    do begin @(negedge clk); n++; end while (cmp_pin == p0 && n < 50);
    chk(n == 6, "R8 toggle period", n, 6);

    // R8 pulse action
    wr(3'd0, mk(1, 1, 0, 1, 0, 0, 0, 0, 0));
    n = 0;
    do begin @(negedge clk); n++; end while (cmp_pin != 1'b1 && n < 50);
    n = 0;
    do begin @(negedge clk); n++; end while (cmp_pin == 1'b1 && n < 50);
    chk(n == 1, "R8 pulse width", n, 1);
    n = 0;
    do begin @(negedge clk); n++; end while (cmp_pin == 1'b0 && n < 50);
    chk(n == 5, "R8 pulse low gap", n, 5);

    // R8 reserved and none actions hold the pin
    wr(3'd0, mk(1, 1, 0, 2, 0, 0, 0, 0, 0));
    n = 0;
    do begin @(negedge clk); n++; end while (cmp_pin != 1'b1 && n < 50);
    wr(3'd0, mk(1, 1, 0, 3, 0, 0, 0, 0, 0));
    bad = 0;
    for (int k = 0; k < 24; k++) begin @(negedge clk); if (cmp_pin != 1'b1) bad++; end
    chk(bad == 0, "R8 reserved action holds pin", bad, 0);
    wr(3'd0, mk(1, 1, 0, 0, 0, 0, 0, 0, 0));
    bad = 0;
    for (int k = 0; k < 24; k++) begin @(negedge clk); if (cmp_pin != 1'b1) bad++; end
    chk(bad == 0, "R8 none action holds pin", bad, 0);

    // R6 capture edge selection (counter stopped)
    wr(3'd0, mk(0, 0, 1, 0, 0, 0, 0, 0, 0));
    wr(3'd4, 32'h3);
    wr(3'd3, 32'hABCD_0001);
    drive_cap(1'b1);
    rd(3'd2, v);
    chk(v == 32'hABCD_0001, "R6 rising capture value", v, 32'hABCD_0001);
    rd(3'd4, v);
    chk(v[0] == 1'b1, "R6 capture flag", v, 1);
    wr(3'd4, 32'h1);
    rd(3'd4, v);
    chk(v[0] == 1'b0, "R9 write one clears flag", v, 0);
    wr(3'd0, mk(0, 0, 2, 0, 0, 0, 0, 0, 0));
    wr(3'd3, 32'h55);
    drive_cap(1'b0);
    rd(3'd2, v);
    chk(v == 32'h55, "R6 falling capture value", v, 32'h55);
    wr(3'd4, 32'h1);
    wr(3'd3, 32'h66);
    drive_cap(1'b1);
    rd(3'd2, v);
    chk(v == 32'h55, "R6 rising ignored in falling mode", v, 32'h55);
    rd(3'd4, v);
    chk(v[0] == 1'b0, "R6 no flag on ignored edge", v, 0);
    wr(3'd0, mk(0, 0, 3, 0, 0, 0, 0, 0, 0));
    wr(3'd3, 32'h77);
    drive_cap(1'b0);
    rd(3'd2, v);
    chk(v == 32'h77, "R6 both-edge fall", v, 32'h77);
    wr(3'd3, 32'h88);
    drive_cap(1'b1);
    rd(3'd2, v);
    chk(v == 32'h88, "R6 both-edge rise", v, 32'h88);
    wr(3'd0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(3'd4, 32'h3);
    wr(3'd3, 32'h99);
    drive_cap(1'b0);
    rd(3'd2, v);
    chk(v == 32'h88, "R6 edge off ignores pin", v, 32'h88);
    rd(3'd4, v);
    chk(v[0] == 1'b0, "R6 edge off no flag", v, 0);

    // R9 sticky across cycles, R10 irq routing
    wr(3'd0, mk(0, 0, 1, 0, 1, 0, 0, 0, 0));
    drive_cap(1'b1);
    repeat (10) @(negedge clk);
    rd(3'd4, v);
    chk(v[0] == 1'b1, "R9 flag sticky", v, 1);
    chk(irq == 1'b1 && dma_req == 1'b0, "R10 enabled capture irq", {irq, dma_req}, 2);
    wr(3'd4, 32'h1);
    chk(irq == 1'b0, "R10 irq drops after clear", irq, 0);
    wr(3'd0, mk(0, 0, 2, 0, 0, 0, 0, 0, 0));
    drive_cap(1'b0);
    chk(irq == 1'b0, "R10 masked capture no irq", irq, 0);

    // R11 DMA routing
    wr(3'd4, 32'h3);
    wr(3'd0, mk(0, 0, 1, 0, 1, 1, 0, 0, 0));
    drive_cap(1'b1);
    chk(dma_req == 1'b1 && irq == 1'b0, "R11 dma instead of irq", {irq, dma_req}, 1);
    wr(3'd4, 32'h1);
    repeat (4) @(negedge clk);
    chk(dma_req == 1'b1, "R11 dma held after flag clear", dma_req, 1);
    @(negedge clk); dma_ack = 1'b1;
    @(negedge clk); dma_ack = 1'b0;
    chk(dma_req == 1'b0, "R11 dma cleared by ack", dma_req, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule